// File: doc/BRIEF.md
# Two-Packet Endpoint Transmit Buffer

This block buffers outgoing bytes for a single endpoint and can hold two complete packets, called data sets, at the same time. A processor-side port pushes bytes one by one and then commits a data set by writing its byte count. A bus-side port pulls bytes out in order. After a transaction, the bus side reports either success or failure. On success the data set is retired. On failure the data set is replayed from its first byte, so no data is lost.

Three pointers work on a power-of-two circular byte store. The write pointer is where the next byte goes. The read pointer is the next byte to present. The read marker holds the first byte of the oldest committed data set. A small state machine tracks which of the two data-set slots are occupied. Each slot also keeps that data set's 10-bit byte count.

The occupancy states are as follows:
- `SET_NONE_W0`: empty; the next commit uses slot 0.
- `SET_NONE_W1`: empty; the next commit uses slot 1.
- `SET_ONLY0`: only slot 0 holds a data set.
- `SET_ONLY1`: only slot 1 holds a data set.
- `SET_BOTH_OLD0`: both slots are full and slot 0 is older.
- `SET_BOTH_OLD1`: both slots are full and slot 1 is older.

The transitions are as follows:
- A commit moves NONE_W0 to ONLY0, NONE_W1 to ONLY1, ONLY0 to BOTH_OLD0 and ONLY1 to BOTH_OLD1.
- A retire moves ONLY0 to NONE_W1, ONLY1 to NONE_W0, BOTH_OLD0 to ONLY1 and BOTH_OLD1 to ONLY0.
- A commit and a retire in the same cycle move ONLY0 to ONLY1 and ONLY1 to ONLY0.
- A clear returns any state to NONE_W0.

Top module: `dpf_tx_fifo`

## Requirements
- R1: After reset or a cycle with `fifo_clr` high, `set_flags` is 00, `set_empty` is 1, `overrun` is 0, `head_count` is 0, and all pointers and the marker restart at address 0.
- R2: A `cpu_wr` that is accepted stores `cpu_wdata` at the write pointer, and the write pointer then advances by one. `usb_rdata` always shows the byte at the read pointer. A `usb_rd` while a data set is committed advances the read pointer by one.
- R3: Bit i of `set_flags` is 1 when slot i holds a committed data set. Commits fill the slots alternately, starting with slot 0, so from empty the flags go 00, then 01, then 11.
- R4: With `auto_retire` at 1, a `usb_ok` moves the read marker to the read pointer and frees the oldest slot. From 11 with slot 0 oldest, the flags become 10. The next data set's first byte is then presented.
- R5: A `usb_fail` returns the read pointer to the read marker, so `usb_rdata` shows the first byte of the oldest data set again.
- R6: With `auto_retire` at 0, `usb_ok` retires nothing. A `mark_adv` pulse retires the oldest data set whatever the mode.
- R7: A `cpu_wr` while the store holds DEPTH bytes counted from the read marker sets `overrun`. The byte is discarded and the write pointer does not move.
- R8: A `cpu_commit` while `set_flags` is 11 sets `overrun` and leaves the flags and stored counts unchanged.
- R9: `overrun` stays at 1 until `fifo_clr`, which is the only way to lower it.
- R10: A `usb_rd` while no data set is committed (`set_empty` = 1) is ignored, and the read pointer holds.
- R11: `usb_fail` takes priority over `usb_rd`, `usb_ok` and `mark_adv` in the same cycle. The rewind happens and nothing is retired.
- R12: Pointers wrap modulo DEPTH, so the byte after address DEPTH-1 is stored at and read from address 0.
- R13: `head_count` shows the 10-bit count committed with the oldest data set, and 0 while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Byte write strobe |
| cpu_wdata | input | 8 | Byte to store |
| cpu_commit | input | 1 | Commit a data set |
| cpu_count | input | CNT_W | Byte count of the data set being committed |
| fifo_clr | input | 1 | Clear pointers, marker, slots and overrun |
| auto_retire | input | 1 | Retire on success when 1 |
| mark_adv | input | 1 | Manual retire of the oldest data set |
| usb_rd | input | 1 | Advance the read pointer |
| usb_ok | input | 1 | Transaction succeeded |
| usb_fail | input | 1 | Transaction failed; rewind |
| usb_rdata | output | 8 | Byte at the read pointer |
| set_flags | output | 2 | Slot occupancy flags |
| set_empty | output | 1 | No data set committed |
| overrun | output | 1 | Sticky overrun indication |
| head_count | output | CNT_W | Count of the oldest data set |

## Verification
The bench targets the following corner cases:
- A rewind after a partial read. A design that rewinds to the write side or to address 0 would replay the wrong byte.
- A retire from the both-full state. Clearing the wrong slot would show 01 instead of 10 and report the newer data set's count.
- A write into a completely full store, followed by a wrap to address 0. A pointer that steps on overrun would put the next packet one byte late.
- Same-cycle collisions of fail with success, and reads while empty. A wrong priority would lose a packet or skip its first byte.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    // Occupancy of the two data-set slots, with write and age order encoded
    typedef enum logic [2:0] {
        SET_NONE_W0   = 3'd0,
        SET_NONE_W1   = 3'd1,
        SET_ONLY0     = 3'd2,
        SET_ONLY1     = 3'd3,
        SET_BOTH_OLD0 = 3'd4,
        SET_BOTH_OLD1 = 3'd5
    } set_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/dpf_byte_store.sv
module dpf_byte_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [dpf_pkg::BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [dpf_pkg::BYTE_W-1:0] rd_data
);

    logic [dpf_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dpf_pointers.sv
module dpf_pointers #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rewind,
    input  logic          retire,
    input  logic          sets_avail,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          full,
    output logic          wr_accept
);

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] rd_mark;
    logic [PW-1:0] span;
    logic          rd_step;

    assign span      = wr_ptr - rd_mark;
    assign full      = (span == PW'(DEPTH));
    assign wr_accept = wr_req && !full;
    assign rd_step   = rd_req && sets_avail && !rewind;
    assign wr_addr   = wr_ptr[AW-1:0];
    assign rd_addr   = rd_ptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_mark <= '0;
        end else begin
            if (wr_accept) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rewind) begin
                rd_ptr <= rd_mark;
            end else if (rd_step) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (retire) begin
                rd_mark <= rd_ptr;
            end
        end
    end

    // R5
    rewind_to_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && !clr) |=> (rd_ptr == $past(rd_mark)));

    // R7
    full_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !clr) |=> (wr_ptr == $past(wr_ptr)));

    // R12
    span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        span <= PW'(DEPTH));

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sets_avail && !rewind && !clr) |=> $stable(rd_ptr));

endmodule

// File: rtl/dpf_set_fsm.sv
module dpf_set_fsm
    import dpf_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             commit_req,
    input  logic [CNT_W-1:0] commit_cnt,
    input  logic             retire,
    output logic [1:0]       flags,
    output logic             sets_avail,
    output logic             both_full,
    output logic             commit_accept,
    output logic [CNT_W-1:0] head_cnt
);

    set_state_e       state;
    set_state_e       state_nx;
    logic             wr_slot;
    logic             rd_slot;
    logic [CNT_W-1:0] cnt_ring [2];

    assign commit_accept = commit_req && !both_full;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SET_NONE_W0;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = SET_NONE_W0;
        end else begin
            unique case (state)
                SET_NONE_W0: if (commit_accept) state_nx = SET_ONLY0;
                SET_NONE_W1: if (commit_accept) state_nx = SET_ONLY1;
                SET_ONLY0: begin
                    if (commit_accept && retire)  state_nx = SET_ONLY1;
                    else if (commit_accept)       state_nx = SET_BOTH_OLD0;
                    else if (retire)              state_nx = SET_NONE_W1;
                end
                SET_ONLY1: begin
                    if (commit_accept && retire)  state_nx = SET_ONLY0;
                    else if (commit_accept)       state_nx = SET_BOTH_OLD1;
                    else if (retire)              state_nx = SET_NONE_W0;
                end
                SET_BOTH_OLD0: if (retire) state_nx = SET_ONLY1;
                SET_BOTH_OLD1: if (retire) state_nx = SET_ONLY0;
                default: state_nx = SET_NONE_W0;
            endcase
        end
    end

    // outputs
    always_comb begin
        flags   = 2'b00;
        wr_slot = 1'b0;
        rd_slot = 1'b0;
        unique case (state)
            SET_NONE_W0:   begin flags = 2'b00; wr_slot = 1'b0; rd_slot = 1'b0; end
            SET_NONE_W1:   begin flags = 2'b00; wr_slot = 1'b1; rd_slot = 1'b1; end
            SET_ONLY0:     begin flags = 2'b01; wr_slot = 1'b1; rd_slot = 1'b0; end
            SET_ONLY1:     begin flags = 2'b10; wr_slot = 1'b0; rd_slot = 1'b1; end
            SET_BOTH_OLD0: begin flags = 2'b11; wr_slot = 1'b0; rd_slot = 1'b0; end
            SET_BOTH_OLD1: begin flags = 2'b11; wr_slot = 1'b1; rd_slot = 1'b1; end
            default:       begin flags = 2'b00; wr_slot = 1'b0; rd_slot = 1'b0; end
        endcase
    end

    assign sets_avail = (flags != 2'b00);
    assign both_full  = (flags == 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_ring[0] <= '0;
            cnt_ring[1] <= '0;
        end else if (commit_accept && !clr) begin
            cnt_ring[wr_slot] <= commit_cnt;
        end
    end

    assign head_cnt = sets_avail ? cnt_ring[rd_slot] : '0;

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |=> (flags != 2'b11));

    // R4
    drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_full && retire && !clr) |=> ($countones(flags) == 1));

    // R8
    full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_full && commit_req && !retire && !clr) |=> (flags == 2'b11));

endmodule

// File: rtl/dpf_tx_fifo.sv
module dpf_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    input  logic             cpu_commit,
    input  logic [CNT_W-1:0] cpu_count,
    input  logic             fifo_clr,
    input  logic             auto_retire,
    input  logic             mark_adv,
    input  logic             usb_rd,
    input  logic             usb_ok,
    input  logic             usb_fail,
    output logic [7:0]       usb_rdata,
    output logic [1:0]       set_flags,
    output logic             set_empty,
    output logic             overrun,
    output logic [CNT_W-1:0] head_count
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          full;
    logic          wr_accept;
    logic          sets_avail;
    logic          both_full;
    logic          commit_accept;
    logic          retire;

    assign retire = sets_avail && !usb_fail && ((usb_ok && auto_retire) || mark_adv);

    dpf_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_accept && !fifo_clr),
        .wr_addr (wr_addr),
        .wr_data (cpu_wdata),
        .rd_addr (rd_addr),
        .rd_data (usb_rdata)
    );

    dpf_pointers #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr_req     (cpu_wr),
        .rd_req     (usb_rd),
        .rewind     (usb_fail),
        .retire     (retire),
        .sets_avail (sets_avail),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .full       (full),
        .wr_accept  (wr_accept)
    );

    dpf_set_fsm #(.CNT_W(CNT_W)) u_sets (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (fifo_clr),
        .commit_req    (cpu_commit),
        .commit_cnt    (cpu_count),
        .retire        (retire),
        .flags         (set_flags),
        .sets_avail    (sets_avail),
        .both_full     (both_full),
        .commit_accept (commit_accept),
        .head_cnt      (head_count)
    );

    assign set_empty = !sets_avail;

    always_ff @(posedge clk) begin
        if (!rst_n || fifo_clr) begin
            overrun <= 1'b0;
        end else if ((cpu_wr && full) || (cpu_commit && both_full)) begin
            overrun <= 1'b1;
        end
    end

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !fifo_clr) |=> overrun);

    // R1
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (set_empty && !overrun && set_flags == 2'b00));

    // R8
    commit_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_commit && !commit_accept && !fifo_clr) |=> overrun);

endmodule

// File: tb/dpf_tx_fifo_bench.sv
module dpf_tx_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int CNT_W      = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_wr = 1'b0;
    logic [7:0]       cpu_wdata = '0;
    logic             cpu_commit = 1'b0;
    logic [CNT_W-1:0] cpu_count = '0;
    logic             fifo_clr = 1'b0;
    logic             auto_retire = 1'b1;
    logic             mark_adv = 1'b0;
    logic             usb_rd = 1'b0;
    logic             usb_ok = 1'b0;
    logic             usb_fail = 1'b0;
    logic [7:0]       usb_rdata;
    logic [1:0]       set_flags;
    logic             set_empty;
    logic             overrun;
    logic [CNT_W-1:0] head_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0]       m_mem [DEPTH];
    int               m_wr, m_rd, m_mark, m_ws, m_rs;
    logic [1:0]       m_bits;
    logic [CNT_W-1:0] m_cnt [2];
    logic             m_ovr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpf_tx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dpf_tx_fifo (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_commit(cpu_commit), .cpu_count(cpu_count), .fifo_clr(fifo_clr),
        .auto_retire(auto_retire), .mark_adv(mark_adv), .usb_rd(usb_rd),
        .usb_ok(usb_ok), .usb_fail(usb_fail), .usb_rdata(usb_rdata),
        .set_flags(set_flags), .set_empty(set_empty), .overrun(overrun),
        .head_count(head_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_wr = 0; m_rd = 0; m_mark = 0; m_ws = 0; m_rs = 0;
        m_bits = 2'b00; m_ovr = 1'b0;
        m_cnt[0] = '0; m_cnt[1] = '0;
    endfunction

    function automatic logic [CNT_W-1:0] model_head();
        return (m_bits == 2'b00) ? '0 : m_cnt[m_rs];
    endfunction

    function automatic void model_step(bit wr, logic [7:0] wd, bit cw, logic [CNT_W-1:0] cv,
                                       bit rd, bit ok, bit fail, bit adv, bit clr, bit aut);
        bit avail = (m_bits != 2'b00);
        bit ret   = avail && !fail && ((ok && aut) || adv);
        int old_rd = m_rd;
        int old_mark = m_mark;
        if (clr) begin
            model_reset();
            return;
        end
        if (fail) m_rd = old_mark;
        else if (rd && avail) m_rd = old_rd + 1;
        if (ret) m_mark = old_rd;
        if (wr) begin
            if (m_wr - old_mark == DEPTH) m_ovr = 1'b1;
            else begin
                m_mem[m_wr % DEPTH] = wd;
                m_wr++;
            end
        end
        if (cw) begin
            if (m_bits == 2'b11) m_ovr = 1'b1;
            else begin
                m_bits[m_ws] = 1'b1;
                m_cnt[m_ws] = cv;
                m_ws ^= 1;
            end
        end
        if (ret) begin
            m_bits[m_rs] = 1'b0;
            m_rs ^= 1;
        end
    endfunction

    task automatic compare_model();
        chk("R3 flags", 32'(set_flags), 32'(m_bits));
        chk("R13 head_count", 32'(head_count), 32'(model_head()));
        chk("R9 overrun", 32'(overrun), 32'(m_ovr));
        chk("R4 empty", 32'(set_empty), 32'(m_bits == 2'b00));
        if (m_bits != 2'b00 && m_rd < m_wr)
            chk("R2 rdata", 32'(usb_rdata), 32'(m_mem[m_rd % DEPTH]));
    endtask

    task automatic cyc(bit wr, logic [7:0] wd, bit cw, logic [CNT_W-1:0] cv,
                       bit rd, bit ok, bit fail, bit adv, bit clr);
        cpu_wr = wr; cpu_wdata = wd; cpu_commit = cw; cpu_count = cv;
        usb_rd = rd; usb_ok = ok; usb_fail = fail; mark_adv = adv; fifo_clr = clr;
        model_step(wr, wd, cw, cv, rd, ok, fail, adv, clr, auto_retire);
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic put(logic [7:0] b);  cyc(1, b, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic commit(int n);       cyc(0, 0, 1, CNT_W'(n), 0, 0, 0, 0, 0); endtask
    task automatic rd1();               cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
    task automatic idle();              cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic clear();             cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 flags", 32'(set_flags), 32'h0);
        chk("R1 empty", 32'(set_empty), 32'h1);
        chk("R1 overrun", 32'(overrun), 32'h0);
        chk("R1 head_count", 32'(head_count), 32'h0);

        put(8'hA1); put(8'hA2); put(8'hA3); commit(3);
        chk("R3 one set", 32'(set_flags), 32'h1);
        chk("R2 first byte", 32'(usb_rdata), 32'hA1);
        put(8'hB1); put(8'hB2); commit(2);
        chk("R3 two sets", 32'(set_flags), 32'h3);
        chk("R13 oldest count", 32'(head_count), 32'd3);
        rd1(); rd1();
        chk("R2 third byte", 32'(usb_rdata), 32'hA3);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R5 rewind", 32'(usb_rdata), 32'hA1);
        rd1(); rd1(); rd1();
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R4 drain order", 32'(set_flags), 32'h2);
        chk("R4 next set byte", 32'(usb_rdata), 32'hB1);
        chk("R13 next count", 32'(head_count), 32'd2);
        commit(7);
        chk("R3 refill slot0", 32'(set_flags), 32'h3);
        commit(9);
        chk("R8 overrun", 32'(overrun), 32'h1);
        chk("R8 flags kept", 32'(set_flags), 32'h3);
        chk("R8 count kept", 32'(head_count), 32'd2);
        idle();
        chk("R9 sticky", 32'(overrun), 32'h1);
        clear();
        chk("R9 cleared", 32'(overrun), 32'h0);
        chk("R1 clear flags", 32'(set_flags), 32'h0);

        // R10 read while empty ignored
        put(8'hC1); put(8'hC2); rd1(); commit(2);
        chk("R10 read ignored", 32'(usb_rdata), 32'hC1);
        // R11 fail wins
        rd1();
        cyc(0, 0, 0, 0, 1, 1, 1, 0, 0);
        chk("R11 rewound", 32'(usb_rdata), 32'hC1);
        chk("R11 not retired", 32'(set_flags), 32'h1);
        // R6 manual marker
        auto_retire = 1'b0;
        rd1(); rd1();
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R6 no auto retire", 32'(set_flags), 32'h1);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R6 manual retire", 32'(set_empty), 32'h1);
        auto_retire = 1'b1;

        // R7 / R12 full store and wrap
        clear();
        for (int i = 0; i < DEPTH; i++) put(8'(i + 16));
        put(8'hEE);
        chk("R7 overrun on full", 32'(overrun), 32'h1);
        commit(DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R12 byte order", 32'(usb_rdata), 32'(8'(i + 16)));
            rd1();
        end
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        put(8'h5A); commit(1);
        chk("R12 wrap address", 32'(usb_rdata), 32'h5A);
        chk("R7 pointer held", 32'(head_count), 32'd1);
        clear();

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            bit wr, cw, rd, ok, fl, adv, clr;
            auto_retire = ((n / 1000) % 2) == 0;
            wr  = ($urandom % 100) < 45;
            cw  = ($urandom % 100) < 10;
            rd  = (($urandom % 100) < 40) && (m_rd < m_wr);
            ok  = ($urandom % 100) < 8;
            fl  = ($urandom % 100) < 4;
            adv = ($urandom % 100) < 2;
            clr = ($urandom % 1000) < 5;
            cyc(wr, 8'($urandom), cw, CNT_W'($urandom), rd, ok, fl, adv, clr);
        end
        summary();
    end

endmodule